// File: doc/BRIEF.md
# Write-Through Snooping Cache with Invalidation

This block is a small private cache placed between one processor and a bus that several processors share with one memory. A processor read whose word is absent is fetched over the bus, stored locally and returned. A read that finds its word locally is answered without any bus traffic. Every processor write is sent over the bus to memory. If the cache holds that word, its local copy is updated as well. If it does not hold the word, no line is allocated and only memory changes.

Coherence between the caches is kept by invalidation. The block watches the write traffic that the other caches put on the bus. When one of those writes targets an address the block holds, the block drops that line, so the next local read goes to memory for the fresh value. The store is direct-mapped, with one 32-bit word per line. A byte address splits into two ignored offset bits [1:0], an index in bits [5:2] (16 lines by default) and a tag in the remaining upper bits.

A controller state machine sequences each request through these states: IDLE, LOOKUP, ARB, ADDR, WAIT and DONE. The transitions are as follows:
- IDLE goes to LOOKUP when a request is accepted.
- LOOKUP goes to DONE on a read hit, and to ARB on a read miss or on any write.
- ARB goes to ADDR when the grant arrives.
- ADDR goes to WAIT after the single command cycle.
- WAIT goes to DONE when memory signals ready.
- DONE goes to IDLE.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, and `cpu_done`, `bus_req` and `bus_valid` are low. The first read of any address is therefore a miss.
- R2: A read miss raises `bus_req`. It issues one bus read (`bus_we`=0) carrying the request address. When `bus_rdy` is sampled, `cpu_done` pulses on the next cycle with `bus_rdata` on `cpu_rdata`, and the word is stored in the line at address bits [5:2].
- R3: A read hit pulses `cpu_done` exactly two cycles after the request is accepted, with the stored word on `cpu_rdata`. `bus_req` stays low throughout.
- R4: `bus_valid` is asserted for exactly one cycle per transfer and only while `bus_req` and `bus_gnt` are both high. `bus_req` stays high from the grant request until `bus_rdy` is seen.
- R5: Every processor write issues one bus write (`bus_we`=1) with the request address and data. If the word is held, the local copy is replaced, so a later read hits with the new data.
- R6: A write to an address that is not held allocates no line. A later read of it misses and returns the memory value.
- R7: A snooped write (`snp_valid`=1) whose index and tag both match a valid line invalidates that line. The next read of the address misses and returns the current memory value.
- R8: A snooped write with the same index but a different tag leaves the held line valid. A later read still hits.
- R9: If a snooped write hits the index of an outstanding read fill, at any point from arbitration to the ready cycle, the fetched word is still returned. The line is left invalid, so the next read of that address misses.
- R10: A read miss replaces whatever line occupies its index. Reading a second address with the same index evicts the first, and the first then misses.
- R11: `cpu_done` is a single-cycle pulse. A request is accepted only while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_valid | output | 1 | One-cycle bus command strobe |
| bus_we | output | 1 | Bus command direction, 1 = write |
| bus_addr | output | ADDR_W | Bus command address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdy | input | 1 | Memory completion strobe |
| bus_rdata | input | DATA_W | Memory read data, valid with `bus_rdy` |
| snp_valid | input | 1 | A write by another cache is on the bus |
| snp_addr | input | ADDR_W | Address of that snooped write |

## Verification
A hit is due exactly two cycles after acceptance. A miss or a write completes one cycle after the sampled `bus_rdy`. The command strobe follows the sampled grant by one cycle. Snoop effects show up only in whether the next access to the address uses the bus.

The bench drives every input on the falling edge and samples on the falling edge. It counts falling edges from the one that applied the request, and it checks a hit's completion at edge two. A behavioural model predicts hit or miss, bus command count and returned data. During hits the model also compares `bus_req` against zero on every clock. Snoops are injected several cycles into a long memory latency, so they land strictly inside the pending window.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ARB,
        ST_ADDR,
        ST_WAIT,
        ST_DONE
    } wtc_state_e;

endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_valid,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic [TAG_W-1:0]  inv_tag
);

    logic [LINES-1:0]             valid_vec;
    logic [LINES-1:0][TAG_W-1:0]  tag_vec;
    logic [LINES-1:0][DATA_W-1:0] data_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              fill_here;
        logic              inv_here;
        logic              upd_here;

        assign fill_here = fill_en && (fill_idx == IDX_W'(g));
        assign inv_here  = inv_en && v_q && (inv_idx == IDX_W'(g)) && (inv_tag == t_q);
        assign upd_here  = upd_en && v_q && (upd_idx == IDX_W'(g)) && (upd_tag == t_q);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (fill_here) begin
                v_q <= fill_valid;
            end else if (inv_here) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_here) begin
                t_q <= fill_tag;
                d_q <= fill_data;
            end else if (upd_here && !inv_here) begin
                d_q <= upd_data;
            end
        end

        assign valid_vec[g] = v_q;
        assign tag_vec[g]   = t_q;
        assign data_vec[g]  = d_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_vec[rd_idx];
    assign rd_data  = data_vec[rd_idx];

endmodule

// File: rtl/wtc_snoop_watch.sv
module wtc_snoop_watch #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [IDX_W-1:0]  own_idx,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx,
    output logic [TAG_W-1:0]  inv_tag,
    output logic              same_idx
);

    assign inv_en   = snp_valid;
    assign inv_idx  = snp_addr[OFF_W +: IDX_W];
    assign inv_tag  = snp_addr[ADDR_W-1 -: TAG_W];
    assign same_idx = snp_valid && (inv_idx == own_idx);

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  req_idx,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              snp_same_idx,
    output logic              fill_en,
    output logic [TAG_W-1:0]  req_tag,
    output logic              fill_valid,
    output logic              upd_en,
    output logic [DATA_W-1:0] req_wdata
);

    wtc_state_e        state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] resp_q;
    logic              poison_q;
    logic              accept;
    logic              hit;
    logic              pending_rd;
    logic              mem_done;

    assign req_idx    = addr_q[OFF_W +: IDX_W];
    assign req_tag    = addr_q[ADDR_W-1 -: TAG_W];
    assign req_wdata  = wdata_q;
    assign accept     = (state_q == ST_IDLE) && cpu_req;
    assign hit        = rd_valid && (rd_tag == req_tag);
    assign mem_done   = (state_q == ST_WAIT) && bus_rdy;
    assign pending_rd = !we_q && ((state_q == ST_ARB) || (state_q == ST_ADDR) ||
                                  (state_q == ST_WAIT));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (!we_q && hit) ? ST_DONE : ST_ARB;
            ST_ARB:    if (bus_gnt) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_WAIT;
            ST_WAIT:   if (bus_rdy) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture, response and fill poisoning
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            resp_q   <= '0;
            poison_q <= 1'b0;
        end else begin
            if (accept) begin
                we_q     <= cpu_we;
                addr_q   <= cpu_addr;
                wdata_q  <= cpu_wdata;
                poison_q <= 1'b0;
            end else if (pending_rd && snp_same_idx) begin
                poison_q <= 1'b1;
            end
            if ((state_q == ST_LOOKUP) && !we_q && hit) begin
                resp_q <= rd_data;
            end else if (mem_done && !we_q) begin
                resp_q <= bus_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_done  = 1'b0;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOOKUP: ;
            ST_ARB:  bus_req = 1'b1;
            ST_ADDR: begin
                bus_req   = 1'b1;
                bus_valid = 1'b1;
            end
            ST_WAIT: bus_req = 1'b1;
            ST_DONE: cpu_done = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata  = resp_q;
    assign bus_we     = we_q;
    assign bus_addr   = addr_q;
    assign bus_wdata  = wdata_q;
    assign fill_en    = mem_done && !we_q;
    assign fill_valid = !poison_q && !snp_same_idx;
    assign upd_en     = mem_done && we_q;

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [DATA_W-1:0] req_wdata;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              fill_en, fill_valid, upd_en;
    logic              inv_en, same_idx;
    logic [IDX_W-1:0]  inv_idx;
    logic [TAG_W-1:0]  inv_tag;

    wtc_snoop_watch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .own_idx   (req_idx),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx),
        .inv_tag   (inv_tag),
        .same_idx  (same_idx)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_done     (cpu_done),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .bus_valid    (bus_valid),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdy      (bus_rdy),
        .bus_rdata    (bus_rdata),
        .req_idx      (req_idx),
        .rd_valid     (rd_valid),
        .rd_tag       (rd_tag),
        .rd_data      (rd_data),
        .snp_same_idx (same_idx),
        .fill_en      (fill_en),
        .req_tag      (req_tag),
        .fill_valid   (fill_valid),
        .upd_en       (upd_en),
        .req_wdata    (req_wdata)
    );

    wtc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_idx),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_data    (rd_data),
        .fill_en    (fill_en),
        .fill_idx   (req_idx),
        .fill_tag   (req_tag),
        .fill_data  (bus_rdata),
        .fill_valid (fill_valid),
        .upd_en     (upd_en),
        .upd_idx    (req_idx),
        .upd_tag    (req_tag),
        .upd_data   (req_wdata),
        .inv_en     (inv_en),
        .inv_idx    (inv_idx),
        .inv_tag    (inv_tag)
    );

endmodule

// File: rtl/wtc_chk.sv
module wtc_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_done,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_valid,
    input logic bus_rdy
);

    // R4
    strobe_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_req && bus_gnt));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !bus_valid);

    // R4
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(bus_rdy));

    // R2
    ready_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rdy) |=> cpu_done);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cpu_done && !bus_req && !bus_valid));

endmodule

bind wt_snoop_cache wtc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_done  (cpu_done),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_valid (bus_valid),
    .bus_rdy   (bus_rdy)
);

// File: tb/sim_wt_snoop_cache.sv
`timescale 1ns/1ps
module sim_wt_snoop_cache;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_done;
    logic        bus_req, bus_gnt, bus_valid, bus_we, bus_rdy;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        snp_valid;
    logic [31:0] snp_addr;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wt_snoop_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_addr(snp_addr)
    );

    // behavioural model state
    logic [31:0] mem_m   [int unsigned];
    logic [31:0] cache_m [int unsigned];
    int g_delay = 0;
    int m_lat   = 1;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem_m.exists(a >> 2)) return mem_m[a >> 2];
        return a ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus memory and arbiter, driven on falling edges
    int gcnt = 0;
    int pend = 0;
    logic        pend_we;
    logic [31:0] pend_addr;
    always @(negedge clk) begin
        if (bus_rdy) bus_rdy = 1'b0;
        if (!bus_req) begin
            bus_gnt = 1'b0;
            gcnt = 0;
        end else if (!bus_gnt) begin
            if (gcnt >= g_delay) bus_gnt = 1'b1;
            else gcnt++;
        end
        if (bus_valid) begin
            pend = m_lat;
            pend_we = bus_we;
            pend_addr = bus_addr;
            if (bus_we) mem_m[bus_addr >> 2] = bus_wdata;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                bus_rdy = 1'b1;
                bus_rdata = pend_we ? 32'h0 : mem_rd(pend_addr);
            end
        end
    end

    task automatic evict_index(input int unsigned key);
        int unsigned kill[$];
        foreach (cache_m[k]) if ((k & 15) == (key & 15)) kill.push_back(k);
        foreach (kill[i]) cache_m.delete(kill[i]);
    endtask

    task automatic snoop_only(input logic [31:0] a);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_addr  = a;
        if (cache_m.exists(a >> 2)) cache_m.delete(a >> 2);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                         input int gd, input int lat, input int snp_at,
                         input logic [31:0] sa, input string req);
        int unsigned key = a >> 2;
        bit exp_hit = !we && cache_m.exists(key);
        logic [31:0] exp_d = exp_hit ? cache_m[key] : mem_rd(a);
        bit poison = 1'b0;
        int cyc = 0;
        int nbus = 0;
        g_delay = gd;
        m_lat = lat;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            @(negedge clk);
            cyc++;
            if (snp_valid) snp_valid = 1'b0;
            if (cyc == snp_at) begin
                snp_valid = 1'b1;
                snp_addr = sa;
                if (cache_m.exists(sa >> 2)) cache_m.delete(sa >> 2);
                if (!we && (((sa >> 2) & 15) == (key & 15))) poison = 1'b1;
            end
            if (exp_hit) chk(bus_req == 1'b0, {req, " R3 no bus during hit"}, 32'(bus_req), 0);
            if (bus_valid) begin
                nbus++;
                chk(bus_we == we && bus_addr == a, {req, " R2/R5 bus command"}, bus_addr, a);
                if (we) chk(bus_wdata == wd, {req, " R5 bus write data"}, bus_wdata, wd);
            end
            if (cpu_done) break;
            if (cyc > 300) begin
                chk(1'b0, {req, " R11 completion timeout"}, 32'(cyc), 0);
                break;
            end
        end
        cpu_req = 1'b0;
        if (exp_hit) chk(cyc == 2, {req, " R3 hit latency"}, 32'(cyc), 2);
        chk(nbus == (exp_hit ? 0 : 1), {req, " R2/R5 bus command count"}, 32'(nbus), exp_hit ? 0 : 1);
        if (!we) chk(cpu_rdata == exp_d, {req, " read data"}, cpu_rdata, exp_d);
        @(negedge clk);
        if (snp_valid) snp_valid = 1'b0;
        chk(cpu_done == 1'b0, {req, " R11 done is one pulse"}, 32'(cpu_done), 0);
        if (we) begin
            if (cache_m.exists(key)) cache_m[key] = wd;
        end else if (!exp_hit) begin
            evict_index(key);
            if (!poison) cache_m[key] = exp_d;
        end
    endtask

    localparam logic [31:0] A  = 32'h0000_0100;
    localparam logic [31:0] B  = 32'h0000_0140;
    localparam logic [31:0] C  = 32'h0000_0104;
    localparam logic [31:0] C2 = 32'h0000_0184;
    localparam logic [31:0] D  = 32'h0000_0208;

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 1'b0; bus_rdy = 1'b0; bus_rdata = '0; snp_valid = 1'b0; snp_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs after reset
        chk(!cpu_done && !bus_req && !bus_valid, "R1 reset outputs", {29'd0, cpu_done, bus_req, bus_valid}, 0);
        do_op(0, A, 0, 2, 3, 0, 0, "R1 R2 first read misses");
        do_op(0, A, 0, 0, 1, 0, 0, "R3 read hit");
        do_op(1, A, 32'h1111_1111, 1, 2, 0, 0, "R5 write hit");
        do_op(0, A, 0, 0, 1, 0, 0, "R5 read after write hit");
        do_op(1, D, 32'h2222_2222, 0, 1, 0, 0, "R6 write miss");
        do_op(0, D, 0, 3, 1, 0, 0, "R6 read after write miss");
        do_op(0, C, 0, 0, 2, 0, 0, "R7 fill C");
        mem_m[C >> 2] = 32'h3333_3333;
        snoop_only(C);
        do_op(0, C, 0, 0, 1, 0, 0, "R7 read after snoop");
        snoop_only(B);
        do_op(0, A, 0, 0, 1, 0, 0, "R8 other tag snoop");
        do_op(0, B, 0, 1, 1, 0, 0, "R10 conflict fill");
        do_op(0, A, 0, 0, 1, 0, 0, "R10 evicted line misses");
        do_op(0, C2, 0, 0, 8, 5, C, "R9 snoop during fill");
        do_op(0, C2, 0, 0, 1, 0, 0, "R9 poisoned line misses");
        do_op(0, C, 0, 0, 1, 0, 0, "R7 R9 snooped line refetched");
        do_op(0, C, 0, 0, 1, 0, 0, "R3 hit after refetch");
        for (int i = 0; i < 16; i++) begin
            do_op(0, 32'h0000_1000 + 32'(i * 4), 0, i % 3, 1 + i % 4, 0, 0, "R2 sweep fill");
        end
        for (int i = 0; i < 16; i++) begin
            do_op(0, 32'h0000_1000 + 32'(i * 4), 0, 0, 1, 0, 0, "R3 sweep hit");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R11 watchdog expired actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule